// File: doc/BRIEF.md
# Dual-Mode Loss-of-Signal Detector

This block decides whether a receiver has lost its input signal. It uses one of two digital measurement codes that other logic samples. One is a modulation-amplitude code. The other is a mean received-power code. A mode input chooses which code is used. Each code is compared with its own 8-bit assert threshold.

Hysteresis keeps the flag from chattering. Once loss is flagged, the measurement must rise above a higher release level before the flag clears. That release level is derived from the same threshold.

A condition must hold on every timebase tick for a set number of ticks before the flag changes. Each mode has its own tick counts for assert and for release. The flag is reported twice. The status output shows the flag as it is. The pin output can be inverted for boards that want the pin active when a signal is present.

Top module: `los_detector`

## Requirements
- R1: Synchronous active-high reset sets the loss flag (`los_status` = 1) and clears all qualification counts. With `pin_invert` = 0 this gives `los_pin` = 1.
- R2: `det_sel` = 1 selects amplitude detection, using `ampl_code` and `ampl_thr`. `det_sel` = 0 selects mean-power detection, using `power_code` and `power_thr`. The unselected code has no effect.
- R3: While the flag is clear, a tick counts toward loss only when the selected code is less than or equal to its threshold, that is, when it does not exceed it.
- R4: In power mode the release level is `power_thr + (power_thr >> 1)`, saturated at 255. While the flag is set, a tick counts toward release only when `power_code` is strictly greater than this level.
- R5: In amplitude mode the release level is `ampl_thr + (ampl_thr >> 1) + (ampl_thr >> 2)`, saturated at 255. While the flag is set, a tick counts toward release only when `ampl_code` is strictly greater than this level.
- R6: In power mode the flag sets on the 10th consecutive qualifying tick and clears on the 40th.
- R7: In amplitude mode the flag sets on the 100th consecutive qualifying tick and clears on the 20th.
- R8: A tick that does not qualify restarts the count. This includes a code that lies between the assert threshold and the release level.
- R9: A change of `det_sel` clears the counts and leaves the flag as it was. Counting starts again from zero on the next tick.
- R10: `los_pin` equals `los_status` when `pin_invert` = 0, and its complement when `pin_invert` = 1.
- R11: The flag changes only at the clock edge that samples `us_tick` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle timebase pulse, one per microsecond |
| det_sel | input | 1 | Detection mode: 1 amplitude, 0 mean power |
| pin_invert | input | 1 | Pin polarity: 1 drives the pin high while a signal is present |
| ampl_code | input | 8 | Sampled modulation-amplitude measurement |
| power_code | input | 8 | Sampled mean received-power measurement |
| ampl_thr | input | 8 | Amplitude assert threshold |
| power_thr | input | 8 | Power assert threshold |
| los_pin | output | 1 | Loss-of-signal pin after polarity |
| los_status | output | 1 | Loss flag, 1 during loss |

## Verification
The assertions check on every cycle that:
- the flag moves only on tick edges;
- a mode change never moves the flag;
- every set of the flag follows a sample at or below the threshold;
- every clear follows a sample above the saturated release level;
- the pin tracks the flag with the selected polarity.

Only the bench scenarios can show the exact tick counts per mode and direction. They also show that an interrupting or in-between sample restarts the count, and that a saturated release level blocks recovery at code 255. They also show that the unselected code is ignored. The bench compares both outputs with its behavioural model on every clock.

// File: rtl/los_pkg.sv
package los_pkg;

    localparam int LOS_CODE_W = 8;
    localparam int LOS_CODE_MAX = (1 << LOS_CODE_W) - 1;

    typedef enum logic {
        DET_POWER = 1'b0,
        DET_AMPL  = 1'b1
    } det_mode_e;

    typedef logic [LOS_CODE_W-1:0] code_t;

    typedef struct packed {
        code_t set_lvl;
        code_t clr_lvl;
    } level_pair_t;

    // Release level above the assert threshold, saturating at full scale.
    function automatic code_t release_level(input code_t thr, input det_mode_e m);
        logic [LOS_CODE_W+1:0] sum;
        sum = {2'b00, thr} + {3'b000, thr[LOS_CODE_W-1:1]};
        if (m == DET_AMPL)
            sum = sum + {4'b0000, thr[LOS_CODE_W-1:2]};
        if (sum > (LOS_CODE_W+2)'(LOS_CODE_MAX))
            return code_t'(LOS_CODE_MAX);
        return sum[LOS_CODE_W-1:0];
    endfunction

endpackage

// File: rtl/los_levels.sv
module los_levels
    import los_pkg::*;
(
    input  code_t       thr,
    input  det_mode_e   mode,
    output level_pair_t lv
);
    always_comb begin
        lv.set_lvl = thr;
        lv.clr_lvl = release_level(thr, mode);
    end
endmodule

// File: rtl/los_qualifier.sv
module los_qualifier
    import los_pkg::*;
#(
    parameter int SET_TICKS = 10,
    parameter int CLR_TICKS = 40,
    localparam int MAX_TICKS = (SET_TICKS > CLR_TICKS) ? SET_TICKS : CLR_TICKS,
    localparam int CNT_W = $clog2(MAX_TICKS + 1)
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        clear,
    input  logic        tick,
    input  logic        flag,
    input  code_t       meas,
    input  level_pair_t lv,
    output logic        flip
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             qual;

    always_comb begin
        qual = flag ? (meas > lv.clr_lvl) : (meas <= lv.set_lvl);
        last = flag ? CNT_W'(CLR_TICKS - 1) : CNT_W'(SET_TICKS - 1);
        flip = enable && !clear && tick && qual && (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (rst || clear || !enable) begin
            cnt <= '0;
        end else if (tick) begin
            if (!qual || cnt == last)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/los_pin_drive.sv
module los_pin_drive (
    input  logic flag,
    input  logic invert,
    output logic pin,
    output logic status
);
    always_comb begin
        status = flag;
        pin    = invert ? ~flag : flag;
    end
endmodule

// File: rtl/los_detector.sv
module los_detector
    import los_pkg::*;
#(
    parameter int PWR_SET_TICKS = 10,
    parameter int PWR_CLR_TICKS = 40,
    parameter int AMP_SET_TICKS = 100,
    parameter int AMP_CLR_TICKS = 20
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  us_tick,
    input  logic                  det_sel,
    input  logic                  pin_invert,
    input  logic [LOS_CODE_W-1:0] ampl_code,
    input  logic [LOS_CODE_W-1:0] power_code,
    input  logic [LOS_CODE_W-1:0] ampl_thr,
    input  logic [LOS_CODE_W-1:0] power_thr,
    output logic                  los_pin,
    output logic                  los_status
);
    localparam int N_MODES = 2;

    det_mode_e   mode_q;
    det_mode_e   mode_now;
    logic        mode_chg;
    logic        flag_q;
    code_t       meas [N_MODES];
    code_t       thr  [N_MODES];
    level_pair_t lv   [N_MODES];
    logic [N_MODES-1:0] flip;

    assign mode_now = det_mode_e'(det_sel);
    assign mode_chg = (mode_now != mode_q);

    assign meas[DET_POWER] = power_code;
    assign meas[DET_AMPL]  = ampl_code;
    assign thr[DET_POWER]  = power_thr;
    assign thr[DET_AMPL]   = ampl_thr;

    for (genvar g = 0; g < N_MODES; g++) begin : g_mode
        localparam int ST = (g == int'(DET_AMPL)) ? AMP_SET_TICKS : PWR_SET_TICKS;
        localparam int CT = (g == int'(DET_AMPL)) ? AMP_CLR_TICKS : PWR_CLR_TICKS;

        los_levels u_lv (
            .thr  (thr[g]),
            .mode (det_mode_e'(g)),
            .lv   (lv[g])
        );

        los_qualifier #(.SET_TICKS(ST), .CLR_TICKS(CT)) u_q (
            .clk    (clk),
            .rst    (rst),
            .enable (mode_now == det_mode_e'(g)),
            .clear  (mode_chg),
            .tick   (us_tick),
            .flag   (flag_q),
            .meas   (meas[g]),
            .lv     (lv[g]),
            .flip   (flip[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= DET_POWER;
            flag_q <= 1'b1;
        end else begin
            mode_q <= mode_now;
            if (|flip)
                flag_q <= ~flag_q;
        end
    end

    los_pin_drive u_pin (
        .flag   (flag_q),
        .invert (pin_invert),
        .pin    (los_pin),
        .status (los_status)
    );
endmodule

// File: rtl/los_detector_chk.sv
module los_detector_chk
    import los_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        us_tick,
    input logic        det_sel,
    input logic        pin_invert,
    input logic [7:0]  ampl_code,
    input logic [7:0]  power_code,
    input logic [7:0]  ampl_thr,
    input logic [7:0]  power_thr,
    input logic        los_pin,
    input logic        los_status
);
    p_only_on_tick_r11: assert property (@(posedge clk) disable iff (rst)
        !us_tick |=> $stable(los_status));

    p_keep_on_mode_r9: assert property (@(posedge clk) disable iff (rst)
        (det_sel != $past(det_sel)) |=> $stable(los_status));

    p_set_cond_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(los_status) |-> $past(det_sel ? (ampl_code <= ampl_thr)
                                            : (power_code <= power_thr)));

    p_clr_cond_r4_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(los_status) |-> $past(det_sel
            ? (ampl_code  > release_level(ampl_thr,  DET_AMPL))
            : (power_code > release_level(power_thr, DET_POWER))));

    p_pin_pol_r10: assert property (@(posedge clk) disable iff (rst)
        los_pin == (pin_invert ? ~los_status : los_status));
endmodule

bind los_detector los_detector_chk u_chk (
    .clk(clk), .rst(rst), .us_tick(us_tick), .det_sel(det_sel),
    .pin_invert(pin_invert), .ampl_code(ampl_code), .power_code(power_code),
    .ampl_thr(ampl_thr), .power_thr(power_thr), .los_pin(los_pin),
    .los_status(los_status)
);

// File: tb/tb_los_detector.sv
module tb_los_detector;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       us_tick = 1'b0;
    logic       det_sel = 1'b0;
    logic       pin_invert = 1'b0;
    logic [7:0] ampl_code = 8'd0;
    logic [7:0] power_code = 8'd0;
    logic [7:0] ampl_thr = 8'd40;
    logic [7:0] power_thr = 8'd100;
    logic       los_pin;
    logic       los_status;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    int m_flag = 1;
    int m_cnt = 0;
    int m_mode = 0;

    always #4 clk = ~clk;

    los_detector dut (
        .clk(clk), .rst(rst), .us_tick(us_tick), .det_sel(det_sel),
        .pin_invert(pin_invert), .ampl_code(ampl_code), .power_code(power_code),
        .ampl_thr(ampl_thr), .power_thr(power_thr), .los_pin(los_pin),
        .los_status(los_status)
    );

    function automatic int rel(int t, int amp);
        int r;
        r = t + (t >> 1) + (amp != 0 ? (t >> 2) : 0);
        return (r > 255) ? 255 : r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_flag = 1; m_cnt = 0; m_mode = 0;
        end else begin
            if (int'(det_sel) != m_mode) begin
                m_cnt = 0;
            end else if (us_tick) begin
                int meas, t, lim;
                bit ok;
                meas = det_sel ? int'(ampl_code) : int'(power_code);
                t    = det_sel ? int'(ampl_thr)  : int'(power_thr);
                if (m_flag == 1) begin
                    ok  = meas > rel(t, int'(det_sel));
                    lim = det_sel ? 20 : 40;
                end else begin
                    ok  = meas <= t;
                    lim = det_sel ? 100 : 10;
                end
                if (ok) begin
                    m_cnt++;
                    if (m_cnt == lim) begin m_flag = 1 - m_flag; m_cnt = 0; end
                end else begin
                    m_cnt = 0;
                end
            end
            m_mode = int'(det_sel);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // model comparison every clock (R10 pin polarity included)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1-model status", int'(los_status), m_flag);
            chk("R10 pin", int'(los_pin), pin_invert ? 1 - m_flag : m_flag);
        end
    end

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) us_tick = 1'b1;
            @(negedge clk) us_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset status", int'(los_status), 1);
        chk("R1 reset pin", int'(los_pin), 1);

        // R6 release in power mode after 40 ticks; R4 level 150
        power_code = 8'd151; ampl_code = 8'd0;
        ticks(39);
        chk("R6 not yet released", int'(los_status), 1);
        ticks(1);
        chk("R6 released at 40", int'(los_status), 0);
        chk("R2 amplitude code ignored in power mode", int'(los_status), 0);

        // R8 in-between code holds, interrupted loss restarts
        power_code = 8'd120; ticks(30);
        chk("R8 between levels no loss", int'(los_status), 0);
        power_code = 8'd100; ticks(5);
        power_code = 8'd101; ticks(1);
        power_code = 8'd100; ticks(9);
        chk("R8 restart after contrary tick", int'(los_status), 0);
        ticks(1);
        chk("R3 R6 loss at 10th tick", int'(los_status), 1);

        // R4 exact release level does not qualify
        power_code = 8'd150; ticks(45);
        chk("R4 equal to release level", int'(los_status), 1);

        // R4 saturation: thr 200 -> 255, unreachable
        power_thr = 8'd200; power_code = 8'd255; ticks(45);
        chk("R4 saturated release", int'(los_status), 1);
        power_thr = 8'd100;

        // R11 no tick no change
        power_code = 8'd200;
        repeat (200) @(negedge clk);
        chk("R11 no tick no change", int'(los_status), 1);

        // R9 mode change mid count keeps flag and restarts
        ticks(30);
        det_sel = 1'b1; ampl_code = 8'd71;  // amp release level 70
        @(negedge clk);
        chk("R9 flag kept on mode change", int'(los_status), 1);
        ticks(19);
        chk("R7 not released at 19", int'(los_status), 1);
        ticks(1);
        chk("R5 R7 amp release at 20", int'(los_status), 0);

        // R7 amp loss after 100 ticks
        ampl_code = 8'd40; power_code = 8'd0;
        ticks(99);
        chk("R7 no loss at 99", int'(los_status), 0);
        chk("R2 power code ignored in amp mode", int'(los_status), 0);
        ticks(1);
        chk("R7 loss at 100", int'(los_status), 1);

        // R5 exact amp release level
        ampl_code = 8'd70; ticks(25);
        chk("R5 equal release level", int'(los_status), 1);

        // R10 inverted pin
        pin_invert = 1'b1; @(negedge clk);
        chk("R10 inverted pin", int'(los_pin), 0);
        ampl_code = 8'd250; ticks(20);
        chk("R10 inverted pin after release", int'(los_pin), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule